// File: doc/BRIEF.md
# PWM Channel with One-Shot Extra Edge

This block is one pulse-width channel built around a free-running counter. The counter either climbs from zero to a programmed period and restarts (edge-aligned), or climbs to the period and then descends back to zero (center-aligned). The base waveform is high while the counter sits below a duty threshold.

On top of that waveform, a host can request a single extra transition. The host writes a word holding a match value and a direction code into a holding buffer. At the next period start, the buffer is moved into the working registers and a one-shot is armed. The first time the counter equals the match value while moving in the allowed direction, the output is inverted. It stays inverted until the period ends, and the one-shot disarms. Because the buffered values only take effect at period starts, a write never disturbs the waveform part-way through a period.

Top module: `pwm_extra_edge_ch`

## Requirements
- R1: After a synchronous active-low reset, the counter reads 0 and the direction flag reads rising. Nothing is buffered or armed, and the output follows the base waveform with no inversion.
- R2: With `align_center` low, the counter steps 0,1,...,P and then returns to 0, where P is `period`. The direction flag stays low.
- R3: With `align_center` high, the counter steps 0,1,...,P while rising, then P-1,...,1 while falling, then returns to 0. `cnt_down` is high exactly on the falling samples. For P below 2, the count goes from P straight back to 0.
- R4: The base output is 1 when the counter is below `duty` and 0 otherwise. `pwm_out` is the base output XOR an inversion flag.
- R5: A write word holds the match value in bits 15:0 and the direction code in bits 17:16; bits 31:18 are ignored. `wr_data` is ignored while `wr_en` is low. A write does not change the waveform before the next period start.
- R6: At each period start (the edge at which the counter returns to 0), a pending write is copied into the working registers and the one-shot is armed. The inversion flag is cleared at every period start.
- R7: When armed, the output inverts in the same cycle the counter equals the match value under the direction rule. It stays inverted until the period start, and the one-shot disarms. No further extra edge occurs until another write has been applied.
- R8: In center-aligned mode the direction codes are: 0 matches only on rising samples, 1 only on falling samples, 2 on either, and 3 never. The zero and peak samples count as rising.
- R9: In edge-aligned mode the direction code has no effect: every code, including 3, fires on a value match.
- R10: When several writes arrive before a period start, only the last one takes effect.
- R11: A match value above the period never matches, so no extra edge appears.
- R12: A write accepted in the same cycle as a period start is applied at the following period start, not the current one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| align_center | input | 1 | 0: edge-aligned up counter, 1: center-aligned up/down counter |
| period | input | CNT_W | Counter top value P |
| duty | input | CNT_W | Base output is high while the counter is below this value |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | WORD_W | Write word: match value in [CNT_W-1:0], direction code in [CNT_W+1:CNT_W] |
| pwm_out | output | 1 | Channel output |
| cnt_value | output | CNT_W | Current counter value |
| cnt_down | output | 1 | High while the counter is falling |

## Verification
The bench builds the channel with its default 16-bit counter and 32-bit write word. It drives small periods (0, 1, 6, 8 and 9), so every turn-around, wrap and boundary-coincident write occurs within a few dozen cycles. These short periods let every direction code be tried at the zero point, mid-slope and the peak in both alignment modes. They also cover match values beyond the period and duty values at both extremes.

// File: rtl/pwm_xe_pkg.sv
// Package: shared types for the one-shot extra-edge PWM channel.
// Assumes nothing beyond the 2-bit direction code width.
package pwm_xe_pkg;

    // Direction qualifier for the extra edge in center-aligned mode.
    typedef enum logic [1:0] {
        XE_RISE = 2'd0,
        XE_FALL = 2'd1,
        XE_BOTH = 2'd2,
        XE_NONE = 2'd3
    } xe_mode_e;

    localparam int XE_MODE_W = 2;

endpackage

// File: rtl/pwm_xe_counter.sv
// Module: channel counter.
// Counts 0..P and restarts (edge-aligned), or 0..P..1 and restarts
// (center-aligned). Flags the period start edge (wrap_o) one cycle before
// the counter reads zero. Assumes period may change at any time; a
// counter already above the period wraps (edge) or keeps descending (center).
module pwm_xe_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             align_center,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt_o,
    output logic             down_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             down_q, down_d;

    // Next-state selection for count value, direction and period-start flag.
    always_comb begin
        cnt_d  = cnt_q + ONE;
        down_d = 1'b0;
        wrap_o = 1'b0;
        if (!align_center) begin
            if (cnt_q >= period) begin
                cnt_d  = '0;
                wrap_o = 1'b1;
            end
        end else if (down_q) begin
            if (cnt_q <= ONE) begin
                cnt_d  = '0;
                wrap_o = 1'b1;
            end else begin
                cnt_d  = cnt_q - ONE;
                down_d = 1'b1;
            end
        end else if (cnt_q >= period) begin
            if (period < TWO) begin
                cnt_d  = '0;
                wrap_o = 1'b1;
            end else begin
                cnt_d  = period - ONE;
                down_d = 1'b1;
            end
        end
    end

    // Counter and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            down_q <= down_d;
        end
    end

    assign cnt_o  = cnt_q;
    assign down_o = down_q;

    AST_LEFT_RISING: assert property (@(posedge clk) disable iff (!rst_n)
        !align_center |=> !down_q); // R2
    AST_CENTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (align_center && !down_q && cnt_q >= period && period >= TWO) |=> down_q); // R3
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0 && !down_q)); // R6

endmodule

// File: rtl/pwm_xe_shadow.sv
// Module: holding buffer and working registers for the extra edge.
// A write fills the buffer and marks it pending; at the next period start
// the buffer moves into the working registers and load_o pulses so the
// one-shot arms. Assumes WORD_W >= CNT_W + 2; upper word bits are dropped.
module pwm_xe_shadow
    import pwm_xe_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wrap,
    output logic [CNT_W-1:0]  act_val,
    output xe_mode_e          act_mode,
    output logic              load_o
);
    localparam int MODE_LO = CNT_W;
    localparam int MODE_HI = CNT_W + XE_MODE_W - 1;

    logic [CNT_W-1:0] buf_val_q;
    xe_mode_e         buf_mode_q;
    logic             pend_q;
    logic             unused_hi;

    assign unused_hi = ^wr_data[WORD_W-1:MODE_HI+1];

    // Transfer happens only on a period start with a write outstanding.
    assign load_o = wrap && pend_q;

    // Holding buffer capture; the newest write always overwrites.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_val_q  <= '0;
            buf_mode_q <= XE_RISE;
        end else if (wr_en) begin
            buf_val_q  <= wr_data[CNT_W-1:0];
            buf_mode_q <= xe_mode_e'(wr_data[MODE_HI:MODE_LO]);
        end
    end

    // Pending flag: set by a write, consumed at a period start.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (wr_en)   pend_q <= 1'b1;
        else if (wrap)    pend_q <= 1'b0;
    end

    // Working registers, updated only at a period start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_val  <= '0;
            act_mode <= XE_RISE;
        end else if (load_o) begin
            act_val  <= buf_val_q;
            act_mode <= buf_mode_q;
        end
    end

    AST_PEND_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pend_q); // R12
    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_o |=> ($stable(act_val) && $stable(act_mode))); // R5

endmodule

// File: rtl/pwm_xe_oneshot.sv
// Module: direction-qualified one-shot compare and output stage.
// Arms on load, fires once on a value match in an allowed direction,
// and inverts the base duty waveform from the match cycle to the period
// start. Assumes the counter and its direction come from pwm_xe_counter.
module pwm_xe_oneshot
    import pwm_xe_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             align_center,
    input  logic [CNT_W-1:0] cnt,
    input  logic             down,
    input  logic             wrap,
    input  logic             load,
    input  logic [CNT_W-1:0] act_val,
    input  xe_mode_e         act_mode,
    input  logic [CNT_W-1:0] duty,
    output logic             pwm_o
);
    logic armed_q;
    logic flip_q;
    logic dir_ok;
    logic fire;
    logic base;

    // Direction rule: edge-aligned ignores the code, center-aligned decodes it.
    always_comb begin
        if (!align_center) begin
            dir_ok = 1'b1;
        end else begin
            unique case (act_mode)
                XE_RISE: dir_ok = !down;
                XE_FALL: dir_ok = down;
                XE_BOTH: dir_ok = 1'b1;
                default: dir_ok = 1'b0;
            endcase
        end
    end

    // Match detection for the armed one-shot.
    assign fire = armed_q && (cnt == act_val) && dir_ok;

    // Arm state: load arms (and wins over a same-cycle fire), fire disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)    armed_q <= 1'b0;
        else if (load) armed_q <= 1'b1;
        else if (fire) armed_q <= 1'b0;
    end

    // Inversion flag: cleared at period start, set by a fire.
    always_ff @(posedge clk) begin
        if (!rst_n)    flip_q <= 1'b0;
        else if (wrap) flip_q <= 1'b0;
        else if (fire) flip_q <= 1'b1;
    end

    // Output: duty comparison inverted from the match cycle onwards.
    assign base  = (cnt < duty);
    assign pwm_o = base ^ (flip_q | fire);

    AST_ARM_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_q) |-> $past(load)); // R6
    AST_SINGLE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !load) |=> !armed_q); // R7
    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> !flip_q); // R6
    AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (align_center && act_mode == XE_NONE) |-> !fire); // R8
    AST_LEFT_ANY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!align_center && armed_q && cnt == act_val) |-> fire); // R9

endmodule

// File: rtl/pwm_extra_edge_ch.sv
// Module: top of the PWM channel with a one-shot extra edge.
// Ties the counter, the double-buffered edge registers and the one-shot
// output stage together. Assumes a host writes the update word through
// wr_en/wr_data and that the match value lies within 0..period.
module pwm_extra_edge_ch
    import pwm_xe_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              align_center,
    input  logic [CNT_W-1:0]  period,
    input  logic [CNT_W-1:0]  duty,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              pwm_out,
    output logic [CNT_W-1:0]  cnt_value,
    output logic              cnt_down
);
    logic             wrap;
    logic             load;
    logic [CNT_W-1:0] act_val;
    xe_mode_e         act_mode;

    pwm_xe_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .align_center (align_center),
        .period       (period),
        .cnt_o        (cnt_value),
        .down_o       (cnt_down),
        .wrap_o       (wrap)
    );

    pwm_xe_shadow #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wrap     (wrap),
        .act_val  (act_val),
        .act_mode (act_mode),
        .load_o   (load)
    );

    pwm_xe_oneshot #(.CNT_W(CNT_W)) u_shot (
        .clk          (clk),
        .rst_n        (rst_n),
        .align_center (align_center),
        .cnt          (cnt_value),
        .down         (cnt_down),
        .wrap         (wrap),
        .load         (load),
        .act_val      (act_val),
        .act_mode     (act_mode),
        .duty         (duty),
        .pwm_o        (pwm_out)
    );

endmodule

// File: tb/sim_pwm_extra_edge_ch.sv
// Bench: behavioural reference model compared against the channel every clock.
module sim_pwm_extra_edge_ch;
    localparam int CW = 16;
    localparam int WW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          align_center = 1'b0;
    logic [CW-1:0] period = 16'd9;
    logic [CW-1:0] duty = 16'd4;
    logic          wr_en = 1'b0;
    logic [WW-1:0] wr_data = '0;
    logic          pwm_out;
    logic [CW-1:0] cnt_value;
    logic          cnt_down;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    pwm_extra_edge_ch #(.CNT_W(CW), .WORD_W(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .align_center(align_center),
        .period(period), .duty(duty), .wr_en(wr_en), .wr_data(wr_data),
        .pwm_out(pwm_out), .cnt_value(cnt_value), .cnt_down(cnt_down)
    );

    always #2 clk = ~clk;   // 250 MHz

    // Reference model state
    int m_cnt = 0, m_bv = 0, m_bm = 0, m_av = 0, m_am = 0;
    bit m_down = 0, m_pend = 0, m_armed = 0, m_tog = 0;

    function automatic bit dir_allows(bit ctr, bit dn, int code);
        if (!ctr) return 1'b1;
        if (code == 0) return !dn;
        if (code == 1) return dn;
        if (code == 2) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit model_fire();
        return m_armed && (m_cnt == m_av) && dir_allows(align_center, m_down, m_am);
    endfunction

    // Model advance on each rising edge
    always @(posedge clk) begin
        int p, nc;
        bit nd, wrp, f, ld;
        p = int'(period);
        if (!rst_n) begin
            m_cnt = 0; m_down = 0; m_bv = 0; m_bm = 0; m_av = 0; m_am = 0;
            m_pend = 0; m_armed = 0; m_tog = 0;
        end else begin
            f = model_fire();
            wrp = 0; nd = 0; nc = m_cnt + 1;
            if (!align_center) begin
                if (m_cnt >= p) begin nc = 0; wrp = 1; end
            end else if (m_down) begin
                if (m_cnt <= 1) begin nc = 0; wrp = 1; end
                else begin nc = m_cnt - 1; nd = 1; end
            end else if (m_cnt >= p) begin
                if (p < 2) begin nc = 0; wrp = 1; end
                else begin nc = p - 1; nd = 1; end
            end
            ld = wrp && m_pend;
            if (ld) begin m_av = m_bv; m_am = m_bm; end
            if (ld) m_armed = 1; else if (f) m_armed = 0;
            if (wrp) m_tog = 0; else if (f) m_tog = 1;
            if (wr_en) begin
                m_bv = int'(wr_data[15:0]);
                m_bm = int'(wr_data[17:16]);
                m_pend = 1;
            end else if (wrp) m_pend = 0;
            m_cnt = nc; m_down = nd;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
        end
    endtask

    // Per-cycle comparison, sampled 1 ns after the edge
    always @(posedge clk) begin
        int eo;
        #1;
        eo = ((m_cnt < int'(duty)) ? 1 : 0) ^ ((m_tog || model_fire()) ? 1 : 0);
        chk(int'(cnt_value) == m_cnt, tag, "count", int'(cnt_value), m_cnt);
        chk(cnt_down == m_down, tag, "direction", int'(cnt_down), int'(m_down));
        chk(int'(pwm_out) == eo, tag, "output", int'(pwm_out), eo);
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(logic [WW-1:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'hDEAD_BEEF;
    endtask

    function automatic logic [WW-1:0] word(int val, int code);
        return {14'd0, 2'(code), 16'(val)};
    endfunction

    // Watchdog
    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tag = "R1";
        tick(3);
        chk(cnt_value == '0, "R1", "reset count", int'(cnt_value), 0);
        chk(pwm_out == 1'b1, "R1", "reset output", int'(pwm_out), 1);
        rst_n = 1'b1;
        tag = "R2"; tick(25);
        tag = "R4"; duty = 16'd0; tick(12); duty = 16'd10; tick(12); duty = 16'd4;
        tag = "R7"; put(word(6, 1)); tick(35);
        tag = "R9"; put(word(3, 3)); tick(22); put(word(9, 2)); tick(22);
        tag = "R5"; put({14'h3FFF, 2'd0, 16'd2}); tick(22);
        tag = "R10"; put(word(1, 0)); put(word(7, 0)); tick(25);
        tag = "R11"; put(word(20, 2)); tick(25);
        tag = "R12";
        @(negedge clk);
        while (cnt_value != period) @(negedge clk);
        wr_en = 1'b1; wr_data = word(5, 0);
        @(negedge clk); wr_en = 1'b0;
        tick(25);
        tag = "R3"; align_center = 1'b1; period = 16'd8; duty = 16'd3; tick(40);
        tag = "R8";
        for (int code = 0; code < 4; code++) begin
            put(word(5, code)); tick(36);
        end
        put(word(0, 0)); tick(36);
        put(word(8, 1)); tick(36);
        put(word(8, 0)); tick(36);
        put(word(0, 2)); tick(36);
        tag = "R6"; put(word(4, 2)); put(word(6, 1)); tick(40);
        tag = "R3"; period = 16'd1; put(word(1, 0)); tick(12);
        period = 16'd0; tick(8);
        period = 16'd6; put(word(2, 1)); tick(30);
        tag = "R9"; align_center = 1'b0; put(word(6, 1)); tick(25);
        tag = "R1"; rst_n = 1'b0; tick(2);
        chk(cnt_value == '0 && cnt_down == 1'b0, "R1", "second reset", int'(cnt_value), 0);
        rst_n = 1'b1; tick(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule